// File: doc/BRIEF.md
# Execute-Stage Immediate Extension and Overflow Unit

This block is the front of the execute stage of a 32-bit load/store integer core. Each accepted operation carries an operation code, two register operands, a 16-bit immediate and, for loads, the raw memory word with its low address bits. The unit widens the immediate according to the class of the operation, not its signedness. Arithmetic immediates are always sign-widened, even for the non-trapping add. Logical immediates are zero-widened, and the load-upper form shifts the immediate into the top half. It then computes an add, subtract or bitwise result.

A signed two's-complement overflow flag is raised only for the three trapping forms. When that flag is set, the register write enable is dropped, so the destination keeps its old value. A separate path picks a byte or halfword lane out of a loaded word and widens it with sign or zero fill.

Results leave through a single output register on a valid/ready stream. A transfer happens on a clock edge where valid and ready are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output register holds its contents unchanged and no new input is taken.

Top module: `xo_exec_front`

## Requirements
- R1: Op codes 8 (trapping add-immediate) and 9 (non-trapping add-immediate) add `in_a` to the immediate sign-widened to 32 bits, so immediate 0xFFFF adds 0xFFFFFFFF.
- R2: Op codes 10 (and-immediate), 11 (or-immediate) and 12 (xor-immediate) combine `in_a` with the immediate zero-widened to 32 bits, so immediate 0xFFFF acts as 0x0000FFFF.
- R3: Op code 13 (load-upper) yields the immediate in bits 31:16 and zeros in bits 15:0.
- R4: The register-register op codes give the full 32-bit wrapped result: 0 add, 1 add without trap, 2 subtract (a-b), 3 subtract without trap, 4 and, 5 or, 6 xor, 7 nor.
- R5: `out_ovf` is set only for op codes 0, 2 and 8, and only when the signed two's-complement result does not fit in 32 bits. It is never set for any other op code.
- R6: `out_wr_en` is 0 whenever `out_ovf` is 1, and it is 0 for op code 15 (no operation, result 0). Otherwise it is 1.
- R7: Op code 14 extracts from `in_ld_data` using `in_ld_kind`: 0 = signed byte, 1 = unsigned byte, 2 = signed halfword, 3 = unsigned halfword. A byte lane is `in_ld_addr`×8 (lane 0 = bits 7:0). A halfword lane is bits 15:0 when `in_ld_addr[1]`=0 and bits 31:16 when it is 1. Signed kinds sign-fill and unsigned kinds zero-fill.
- R8: An input accepted on a clock edge appears on the outputs with `out_valid` high right after that edge.
- R9: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. In that state the outputs stay unchanged on the next edge.
- R10: A synchronous reset clears `out_valid` and `out_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second register operand |
| in_imm | input | 16 | Immediate field |
| in_ld_data | input | 32 | Loaded memory word |
| in_ld_kind | input | 2 | Load width and fill kind |
| in_ld_addr | input | 2 | Low address bits of the load |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | 32-bit result |
| out_ovf | output | 1 | Signed overflow exception flag |
| out_wr_en | output | 1 | Destination write enable |

## Verification
The only state is the output register and its valid bit, so a fault there shows on the first edge after the affected input. Such a fault appears as a wrong result, a stray or missing overflow flag, or a write enable that disagrees with the flag. A valid bit that is lost or duplicated under back-pressure shows as a result that vanishes or repeats while `out_ready` is low. The bench therefore stalls the consumer at random, so held outputs are compared over several cycles. It also drives operands at the signed range limits, where a sign-widening or overflow error changes the flag in the very next output.

// File: rtl/xo_pkg.sv
package xo_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDU  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBU  = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_NOR   = 4'd7,
    OP_ADDI  = 4'd8,
    OP_ADDIU = 4'd9,
    OP_ANDI  = 4'd10,
    OP_ORI   = 4'd11,
    OP_XORI  = 4'd12,
    OP_LUI   = 4'd13,
    OP_LOAD  = 4'd14,
    OP_NONE  = 4'd15
  } xo_op_e;

  typedef enum logic [1:0] {
    LD_BYTE_S = 2'd0,
    LD_BYTE_U = 2'd1,
    LD_HALF_S = 2'd2,
    LD_HALF_U = 2'd3
  } xo_ld_e;

  // operations whose second operand is the widened immediate
  function automatic logic op_takes_imm(xo_op_e op);
    case (op)
      OP_ADDI, OP_ADDIU, OP_ANDI, OP_ORI, OP_XORI, OP_LUI: op_takes_imm = 1'b1;
      default:                                             op_takes_imm = 1'b0;
    endcase
  endfunction

  // only these forms raise the overflow exception
  function automatic logic op_traps(xo_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_ADDI: op_traps = 1'b1;
      default:                 op_traps = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xo_immext.sv
module xo_immext
  import xo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  xo_op_e              op,
  input  logic [IMM_W-1:0]    imm,
  output logic [DATA_W-1:0]   ext
);
  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    case (op)
      OP_ADDI, OP_ADDIU: ext = {{PAD_W{imm[IMM_W-1]}}, imm};
      OP_LUI:            ext = {imm, {PAD_W{1'b0}}};
      default:           ext = {{PAD_W{1'b0}}, imm};
    endcase
  end
endmodule

// File: rtl/xo_alu.sv
module xo_alu
  import xo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  xo_op_e             op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  output logic [DATA_W-1:0]  res,
  output logic               ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum, diff;
  logic              sum_ovf, diff_ovf;

  assign sum  = a + b;
  assign diff = a - b;
  // same-sign inputs with a flipped result sign
  assign sum_ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  // opposite-sign inputs with the result sign leaving a's sign
  assign diff_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);

  always_comb begin
    ovf = 1'b0;
    case (op)
      OP_ADD, OP_ADDU, OP_ADDI, OP_ADDIU: begin
        res = sum;
        ovf = op_traps(op) && sum_ovf;
      end
      OP_SUB, OP_SUBU: begin
        res = diff;
        ovf = op_traps(op) && diff_ovf;
      end
      OP_AND, OP_ANDI: res = a & b;
      OP_OR,  OP_ORI:  res = a | b;
      OP_XOR, OP_XORI: res = a ^ b;
      OP_NOR:          res = ~(a | b);
      OP_LUI:          res = b;
      default:         res = '0;
    endcase
  end
endmodule

// File: rtl/xo_loadext.sv
module xo_loadext
  import xo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]          data,
  input  logic [$clog2(DATA_W/8)-1:0] addr,
  input  xo_ld_e                     kind,
  output logic [DATA_W-1:0]          value
);
  localparam int BYTES = DATA_W / 8;
  localparam int HALFS = DATA_W / 16;
  localparam int AW    = $clog2(BYTES);

  logic [7:0]  byte_lane [BYTES];
  logic [15:0] half_lane [HALFS];

  genvar gi;
  generate
    for (gi = 0; gi < BYTES; gi++) begin : g_byte
      assign byte_lane[gi] = data[gi*8 +: 8];
    end
    for (gi = 0; gi < HALFS; gi++) begin : g_half
      assign half_lane[gi] = data[gi*16 +: 16];
    end
  endgenerate

  logic [7:0]    bsel;
  logic [15:0]   hsel;
  logic [AW-1:0] hidx;

  assign hidx = addr >> 1;
  assign bsel = byte_lane[addr];
  assign hsel = half_lane[hidx[AW-2:0]];

  always_comb begin
    case (kind)
      LD_BYTE_S: value = {{(DATA_W-8){bsel[7]}}, bsel};
      LD_BYTE_U: value = {{(DATA_W-8){1'b0}}, bsel};
      LD_HALF_S: value = {{(DATA_W-16){hsel[15]}}, hsel};
      default:   value = {{(DATA_W-16){1'b0}}, hsel};
    endcase
  end
endmodule

// File: rtl/xo_exec_front.sv
module xo_exec_front
  import xo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int LA_W   = $clog2(DATA_W/8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [DATA_W-1:0] in_ld_data,
  input  logic [1:0]        in_ld_kind,
  input  logic [LA_W-1:0]   in_ld_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_ovf,
  output logic              out_wr_en
);
  xo_op_e            op;
  logic [DATA_W-1:0] imm_ext, opnd_b, alu_res, ld_val, res_d;
  logic              alu_ovf, take;

  assign op = xo_op_e'(in_op);

  xo_immext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_immext (
    .op(op), .imm(in_imm), .ext(imm_ext)
  );

  assign opnd_b = op_takes_imm(op) ? imm_ext : in_b;

  xo_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op), .a(in_a), .b(opnd_b), .res(alu_res), .ovf(alu_ovf)
  );

  xo_loadext #(.DATA_W(DATA_W)) u_loadext (
    .data(in_ld_data), .addr(in_ld_addr),
    .kind(xo_ld_e'(in_ld_kind)), .value(ld_val)
  );

  assign res_d    = (op == OP_LOAD) ? ld_val : alu_res;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_ovf    <= 1'b0;
      out_wr_en  <= 1'b0;
      out_result <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= res_d;
      out_ovf    <= alu_ovf;
      out_wr_en  <= (op != OP_NONE) && !alu_ovf;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/xo_exec_front_chk.sv
module xo_exec_front_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int LA_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic [IMM_W-1:0]  in_imm,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_ovf,
  input logic              out_wr_en
);
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_ovf));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_ovf) && $stable(out_wr_en)));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op != 4'd0 && in_op != 4'd2 && in_op != 4'd8)
      |=> !out_ovf);

  a_r6_trap_blocks_write: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ovf) |-> !out_wr_en);

  a_r3_upper_only: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 4'd13) |=>
      (out_result == {in_imm_q, {(DATA_W-IMM_W){1'b0}}}));

  logic [IMM_W-1:0] in_imm_q;
  always_ff @(posedge clk) in_imm_q <= in_imm;
endmodule

bind xo_exec_front xo_exec_front_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .LA_W(LA_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_imm(in_imm), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_ovf(out_ovf),
  .out_wr_en(out_wr_en)
);

// File: tb/xo_exec_front_bench.sv
`timescale 1ns/1ps
module xo_exec_front_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_valid, out_ready, out_ovf, out_wr_en;
  logic [3:0]  in_op;
  logic [31:0] in_a, in_b, in_ld_data, out_result;
  logic [15:0] in_imm;
  logic [1:0]  in_ld_kind, in_ld_addr;

  always #4 clk = ~clk;

  xo_exec_front u_xo_exec_front (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .in_ld_data(in_ld_data), .in_ld_kind(in_ld_kind), .in_ld_addr(in_ld_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_ovf(out_ovf), .out_wr_en(out_wr_en)
  );

  typedef struct packed {
    logic [31:0] r;
    logic        ovf;
    logic        we;
    logic [3:0]  op;
  } exp_t;

  exp_t q[$];
  int   vectors = 0, miscompares = 0;
  bit   done = 0, stall_mode = 0, took;

  function automatic bit out_of_range(longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  function automatic exp_t model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                 logic [15:0] imm, logic [31:0] ld,
                                 logic [1:0] kind, logic [1:0] addr);
    exp_t e;
    longint sa, sb, si;
    logic [31:0] zi, si32;
    logic [7:0]  by;
    logic [15:0] hw;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    si = longint'($signed(imm));
    si32 = 32'(si);
    zi = 32'(imm);
    e = '0;
    e.op = op;
    case (op)
      4'd0:  begin e.r = a + b; e.ovf = out_of_range(sa + sb); end
      4'd1:  e.r = a + b;
      4'd2:  begin e.r = a - b; e.ovf = out_of_range(sa - sb); end
      4'd3:  e.r = a - b;
      4'd4:  e.r = a & b;
      4'd5:  e.r = a | b;
      4'd6:  e.r = a ^ b;
      4'd7:  e.r = ~(a | b);
      4'd8:  begin e.r = a + si32; e.ovf = out_of_range(sa + si); end
      4'd9:  e.r = a + si32;
      4'd10: e.r = a & zi;
      4'd11: e.r = a | zi;
      4'd12: e.r = a ^ zi;
      4'd13: e.r = zi * 32'd65536;
      4'd14: begin
        by = 8'(ld >> (32'(addr) * 8));
        hw = addr[1] ? ld[31:16] : ld[15:0];
        case (kind)
          2'd0:    e.r = 32'(int'($signed(by)));
          2'd1:    e.r = 32'(by);
          2'd2:    e.r = 32'(int'($signed(hw)));
          default: e.r = 32'(hw);
        endcase
      end
      default: e.r = 32'd0;
    endcase
    e.we = (op != 4'd15) && !e.ovf;
    return e;
  endfunction

  function automatic string tag_of(exp_t e);
    if (e.ovf || e.op == 4'd0 || e.op == 4'd2) return "R5";
    if (e.op == 4'd15) return "R6";
    if (e.op == 4'd14) return "R7";
    if (e.op == 4'd13) return "R3";
    if (e.op >= 4'd10) return "R2";
    if (e.op >= 4'd8)  return "R1";
    return "R4";
  endfunction

  // one clock: inputs already driven after a falling edge
  task automatic step();
    exp_t f;
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    #1;
    vectors++;
    if (q.size() == 0) begin
      if (out_valid !== 1'b0) begin
        miscompares++;
        $display("FAIL R8: out_valid got %b expected 0", out_valid);
      end
    end else begin
      f = q[0];
      if (out_valid !== 1'b1 || out_result !== f.r || out_ovf !== f.ovf ||
          out_wr_en !== f.we) begin
        miscompares++;
        $display("FAIL %s: op %0d got v%b %h ovf%b we%b expected v1 %h ovf%b we%b",
                 tag_of(f), f.op, out_valid, out_result, out_ovf, out_wr_en,
                 f.r, f.ovf, f.we);
      end
    end
    vectors++;
    if (in_ready !== !(q.size() != 0 && !out_ready)) begin
      miscompares++;
      $display("FAIL R9: in_ready got %b expected %b", in_ready,
               !(q.size() != 0 && !out_ready));
    end
    took = in_valid && in_ready;
    if (q.size() != 0 && out_ready) void'(q.pop_front());
    if (took) q.push_back(model(in_op, in_a, in_b, in_imm, in_ld_data,
                                in_ld_kind, in_ld_addr));
    @(negedge clk);
  endtask

  task automatic send(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                      logic [15:0] imm, logic [31:0] ld, logic [1:0] kind,
                      logic [1:0] addr);
    in_op = op; in_a = a; in_b = b; in_imm = imm;
    in_ld_data = ld; in_ld_kind = kind; in_ld_addr = addr;
    in_valid = 1'b1;
    do step(); while (!took);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    rst = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    in_op = 4'd0; in_a = 32'h7FFF_FFFF; in_b = 32'h1; in_imm = 16'h0;
    in_ld_data = 0; in_ld_kind = 0; in_ld_addr = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || out_ovf !== 1'b0) begin
      miscompares++;
      $display("FAIL R10: valid/ovf got %b/%b expected 0/0", out_valid, out_ovf);
    end
    rst = 1'b0; in_valid = 1'b0;

    // R1: arithmetic immediates are sign-widened
    send(4'd8,  32'h0,        0, 16'hFFFF, 0, 0, 0);
    send(4'd9,  32'h0,        0, 16'h8000, 0, 0, 0);
    send(4'd9,  32'h7FFF_FFFF, 0, 16'h0001, 0, 0, 0);
    send(4'd8,  32'h7FFF_FFFF, 0, 16'h0001, 0, 0, 0);
    send(4'd8,  32'h8000_0000, 0, 16'hFFFF, 0, 0, 0);
    // R2: logical immediates are zero-widened
    send(4'd10, 32'hFFFF_FFFF, 0, 16'hFFFF, 0, 0, 0);
    send(4'd11, 32'h0,        0, 16'h8001, 0, 0, 0);
    send(4'd12, 32'hFFFF_0000, 0, 16'hF0F0, 0, 0, 0);
    // R3
    send(4'd13, 32'h1234_5678, 0, 16'hABCD, 0, 0, 0);
    // R4 / R5: register-register forms at the signed limits
    send(4'd0, 32'h7FFF_FFFF, 32'h1,        0, 0, 0, 0);
    send(4'd1, 32'h7FFF_FFFF, 32'h1,        0, 0, 0, 0);
    send(4'd2, 32'h8000_0000, 32'h1,        0, 0, 0, 0);
    send(4'd3, 32'h8000_0000, 32'h1,        0, 0, 0, 0);
    send(4'd2, 32'h0,        32'h8000_0000, 0, 0, 0, 0);
    send(4'd0, 32'hFFFF_FFFF, 32'h1,        0, 0, 0, 0);
    for (int k = 4; k < 8; k++) send(4'(k), 32'hF0F0_1234, 32'h0FF0_8421, 0, 0, 0, 0);
    // R6: no-operation code
    send(4'd15, 32'h1, 32'h2, 16'h3, 0, 0, 0);
    // R7: every lane and kind
    for (int kd = 0; kd < 4; kd++)
      for (int ad = 0; ad < 4; ad++)
        send(4'd14, 32'h0, 32'h0, 16'h0, 32'h80F1_7F85, 2'(kd), 2'(ad));

    // R8 / R9: random traffic with a stalling consumer and idle gaps
    stall_mode = 1;
    for (int n = 0; n < 600; n++) begin
      if (($urandom % 5) == 0) step();
      else send(4'($urandom), pick(), pick(), 16'($urandom), $urandom,
                2'($urandom), 2'($urandom));
    end
    stall_mode = 0;
    repeat (4) step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule